// File: doc/BRIEF.md
# Halt-Mode Keyboard Scan Sequencer

This block runs from a slow clock while the processor sleeps and scans a ten-line key matrix without any help from software. Each line whose wake bit is set is pulled low in turn for a fixed slot. The next enabled line follows at once. After the last enabled line comes a long quiet gap, and then the frame repeats. Every line that is not being pulled low is an input with its pull-up on. A pressed key joins the line being driven to another line, and that line then falls.

The falling line, or any edge on the separate input-only line, produces a one-cycle wake pulse. Scanning then stops at once and every line goes back to being an input. The block stays quiet until halt is released. On the next halt entry the scan restarts at the first enabled line.

The block has no streaming data path. All of its pins are plain level controls: option, halt, enables, pad levels, output-enable and pull-up controls, and the wake pulse.

Top module: `halt_keyscan`

## Requirements
- R1: Lines are driven, and a wake pulse can be raised, only while `scan_opt_en` and `halt_i` are both 1. With either at 0, `drive_oe` is 0 and `wake_pulse` stays 0.
- R2: At most one bit of `drive_oe` is 1 at any time. A driven line always carries a low level. `pull_en` is the bitwise inverse of `drive_oe`, so every line that is not driven is pulled up.
- R3: Bit index i of `wake_en`, `pad_in`, `drive_oe` and `pull_en` is the i-th line in scan order. The order, from index 0 to index 9, is port A lines 2,1,0, then port B lines 3,2,1,0, then port D lines 2,1,0. Only lines whose `wake_en` bit is 1 are driven, in ascending index order. A disabled line is skipped and uses no time.
- R4: The lowest enabled line is driven from the first rising edge at which scanning is allowed. Each enabled line is driven for `SLOT_CYC` cycles. After the last enabled line, nothing is driven for `GAP_CYC` cycles, and then the frame repeats.
- R5: A rise or fall on an enabled line that is not driven and was not released within the last 3 cycles raises `wake_pulse` on the third rising edge after the change. An edge on a line whose `wake_en` bit is 0 has no effect. The block never wakes on the return of its own driven line.
- R6: `solo_in` is never driven. An edge on it wakes the block, with the same 3-edge latency, when `solo_wake_en` is 1. With all `wake_en` bits at 0, no line is driven, and only `solo_in` can wake the block.
- R7: `wake_pulse` lasts exactly one cycle. `drive_oe` is already 0 in that cycle. No further line is driven and no further pulse is raised until `halt_i` or `scan_opt_en` falls.
- R8: After a wake, the next entry into halt restarts the scan at the lowest enabled line, with the full slot length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_opt_en | input | 1 | Global scan option |
| halt_i | input | 1 | Core is halted |
| wake_en | input | 10 | Per-line scan and wake enable, in scan order |
| solo_wake_en | input | 1 | Wake enable for the input-only line |
| pad_in | input | 10 | Pad levels of the scan lines |
| solo_in | input | 1 | Pad level of the input-only line |
| drive_oe | output | 10 | 1 = drive this line low |
| pull_en | output | 10 | 1 = pull-up on for this line |
| wake_pulse | output | 1 | One-cycle wake request |

## Verification
A wrong line pointer shows up at `drive_oe` as the wrong one-hot value within one slot of the fault. A slot or gap counter that is off by one shifts every later pulse, and the error shows within a single frame. A faulty release mask shows as a spurious `wake_pulse` three edges after a line is released, even with no key pressed. A stuck wake latch shows as a second pulse, or as lines driven after a wake, on the following cycles. All 1024 enable patterns are swept over two full frames and compared cycle by cycle against a trace computed in the bench.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
  localparam int NPINS = 10;
  localparam int IW    = 4;

  typedef enum logic [1:0] {KS_IDLE, KS_DRIVE, KS_GAP} ks_state_e;

  typedef struct packed {
    logic          hit;
    logic [IW-1:0] pos;
  } ks_hit_t;

  // lowest set bit of m at or above index start
  function automatic ks_hit_t first_set(input logic [NPINS-1:0] m, input int start);
    ks_hit_t r;
    r = '0;
    for (int i = NPINS - 1; i >= 0; i--) begin
      if (i >= start && m[i]) begin
        r.hit = 1'b1;
        r.pos = IW'(i);
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/keyscan_sync.sv
module keyscan_sync #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= d;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign edge_o = s2 ^ s3;
endmodule

// File: rtl/keyscan_seq.sv
module keyscan_seq
  import keyscan_pkg::*;
#(
  parameter int SLOT_CYC = 16,
  parameter int GAP_CYC  = 364
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [NPINS-1:0] wake_en,
  output logic [NPINS-1:0] drive_oe
);
  localparam int MAXC = (SLOT_CYC > GAP_CYC) ? SLOT_CYC : GAP_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  ks_state_e     state;
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  ks_hit_t       nxt;

  always_comb begin
    nxt = first_set(wake_en, (state == KS_DRIVE) ? int'(idx) + 1 : 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= KS_IDLE;
      idx   <= '0;
      cnt   <= '0;
    end else if (!run) begin
      state <= KS_IDLE;
      idx   <= '0;
      cnt   <= '0;
    end else begin
      case (state)
        KS_IDLE: begin
          if (nxt.hit) begin
            state <= KS_DRIVE;
            idx   <= nxt.pos;
            cnt   <= '0;
          end
        end
        KS_DRIVE: begin
          if (cnt == CW'(SLOT_CYC - 1)) begin
            cnt <= '0;
            if (nxt.hit) begin
              idx <= nxt.pos;
            end else begin
              state <= KS_GAP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        KS_GAP: begin
          if (cnt == CW'(GAP_CYC - 1)) begin
            cnt <= '0;
            if (nxt.hit) begin
              state <= KS_DRIVE;
              idx   <= nxt.pos;
            end else begin
              state <= KS_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= KS_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_oe
    assign drive_oe[g] = (state == KS_DRIVE) && (idx == IW'(g));
  end

  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drive_oe)); // R2
  AST_DRIVE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_oe != '0 && drive_oe != $past(drive_oe)) |-> ((drive_oe & $past(wake_en)) != '0)); // R3
  AST_DRIVE_ONLY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_oe != '0) |-> $past(run)); // R1
endmodule

// File: rtl/keyscan_wake.sv
module keyscan_wake
  import keyscan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [NPINS-1:0] pin_edge,
  input  logic             solo_edge,
  input  logic [NPINS-1:0] wake_en,
  input  logic             solo_wake_en,
  input  logic [NPINS-1:0] drive_oe,
  output logic             wake_req,
  output logic             woken,
  output logic             wake_pulse
);
  logic [NPINS-1:0] d1, d2, d3, mask, hits;
  logic             any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 <= '0;
      d2 <= '0;
      d3 <= '0;
    end else begin
      d1 <= drive_oe;
      d2 <= d1;
      d3 <= d2;
    end
  end

  // a line is blind while driven and for three cycles after release
  assign mask     = drive_oe | d1 | d2 | d3;
  assign hits     = pin_edge & wake_en & ~mask;
  assign any_hit  = (|hits) | (solo_edge & solo_wake_en);
  assign wake_req = active & ~woken & any_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      woken      <= 1'b0;
      wake_pulse <= 1'b0;
    end else if (!active) begin
      woken      <= 1'b0;
      wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= wake_req;
      if (wake_req) woken <= 1'b1;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R7
  AST_PULSE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(active)); // R1
endmodule

// File: rtl/halt_keyscan.sv
module halt_keyscan
  import keyscan_pkg::*;
#(
  parameter int SLOT_CYC = 16,
  parameter int GAP_CYC  = 364
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_opt_en,
  input  logic             halt_i,
  input  logic [NPINS-1:0] wake_en,
  input  logic             solo_wake_en,
  input  logic [NPINS-1:0] pad_in,
  input  logic             solo_in,
  output logic [NPINS-1:0] drive_oe,
  output logic [NPINS-1:0] pull_en,
  output logic             wake_pulse
);
  logic             active, run, wake_req, woken;
  logic [NPINS:0]   edges;

  assign active = scan_opt_en & halt_i;
  assign run    = active & ~woken & ~wake_req;

  keyscan_sync #(.W(NPINS + 1)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .d      ({solo_in, pad_in}),
    .edge_o (edges)
  );

  keyscan_seq #(.SLOT_CYC(SLOT_CYC), .GAP_CYC(GAP_CYC)) seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .wake_en  (wake_en),
    .drive_oe (drive_oe)
  );

  keyscan_wake wake_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (active),
    .pin_edge     (edges[NPINS-1:0]),
    .solo_edge    (edges[NPINS]),
    .wake_en      (wake_en),
    .solo_wake_en (solo_wake_en),
    .drive_oe     (drive_oe),
    .wake_req     (wake_req),
    .woken        (woken),
    .wake_pulse   (wake_pulse)
  );

  assign pull_en = ~drive_oe;

  AST_STOP_ON_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (drive_oe == '0)); // R7
  AST_NO_DRIVE_AFTER_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_pulse && active) |=> (drive_oe == '0)); // R7
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(active) |-> (drive_oe == '0 && !wake_pulse)); // R1
endmodule

// File: tb/halt_keyscan_tb_top.sv
module halt_keyscan_tb_top;
  localparam int N    = 10;
  localparam int SLOT = 4;
  localparam int GAP  = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         opt = 1'b0, halt = 1'b0, solo_en = 1'b0, solo = 1'b1;
  logic [N-1:0] wen = '0;
  logic [N-1:0] pads;
  logic [N-1:0] oe, pull;
  logic         wp;
  logic         key_on = 1'b0;
  int           ka = 0, kb = 0;
  int           tests = 0, fails = 0;

  always #5 clk = ~clk;

  halt_keyscan #(.SLOT_CYC(SLOT), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .scan_opt_en(opt), .halt_i(halt),
    .wake_en(wen), .solo_wake_en(solo_en), .pad_in(pads), .solo_in(solo),
    .drive_oe(oe), .pull_en(pull), .wake_pulse(wp)
  );

  // pad model: a driven line is low; a pressed key shorts two lines
  always_comb begin
    for (int i = 0; i < N; i++) begin
      pads[i] = !oe[i];
      if (key_on && ((i == ka && oe[kb]) || (i == kb && oe[ka]))) pads[i] = 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nth_set(input logic [N-1:0] m, input int k);
    int c = 0;
    for (int i = 0; i < N; i++) begin
      if (m[i]) begin
        if (c == k) return i;
        c++;
      end
    end
    return -1;
  endfunction

  function automatic logic [N-1:0] exp_oe(input logic [N-1:0] m, input int c);
    int n = $countones(m);
    int per = n * SLOT + GAP;
    int p;
    if (n == 0) return '0;
    p = c % per;
    if (p < n * SLOT) return N'(1) << nth_set(m, p / SLOT);
    return '0;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // run n cycles, count wake pulses and drive activity
  task automatic watch(input int n, output int pulses, output int drives);
    pulses = 0;
    drives = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (wp) pulses++;
      if (oe != '0) drives++;
    end
  endtask

  task automatic leave_halt();
    halt = 1'b0;
    step();
    step();
  endtask

  initial begin
    int pc, dc, bad, first_c;
    logic [N-1:0] got, want;
    @(negedge clk);
    @(negedge clk);
    check(oe == '0 && wp == 1'b0, "R1 reset outputs", {oe, wp}, 0);
    check(pull == '1, "R2 reset pull-ups", pull, 10'h3ff);
    rst_n = 1'b1;
    step();

    // R1: halt without option, option without halt
    wen = '1; solo_en = 1'b1; halt = 1'b1; opt = 1'b0;
    step();
    solo = 1'b0;
    watch(40, pc, dc);
    check(pc == 0 && dc == 0, "R1 option off", pc + dc, 0);
    halt = 1'b0; opt = 1'b1;
    solo = 1'b1;
    watch(40, pc, dc);
    check(pc == 0 && dc == 0, "R1 halt off", pc + dc, 0);
    solo_en = 1'b0;

    // R2 R3 R4 R5: sweep every enable pattern over two frames, no key
    for (int m = 0; m < 1024; m++) begin
      int per;
      wen = N'(m);
      step();
      halt = 1'b1;
      per = $countones(wen) * SLOT + GAP;
      bad = 0;
      got = '0; want = '0;
      for (int c = 0; c < 2 * per; c++) begin
        step();
        if (oe != exp_oe(wen, c) || pull != ~oe || wp) begin
          if (bad == 0) begin
            got = oe;
            want = exp_oe(wen, c);
          end
          bad++;
        end
      end
      check(bad == 0, $sformatf("R3 R4 R2 R5 sweep mask %0h", m), got, want);
      leave_halt();
    end

    // R5 R7 R8: key joins line 0 and line 5, all enabled
    wen = '1; ka = 0; kb = 5; key_on = 1'b1;
    halt = 1'b1;
    first_c = -1;
    for (int c = 0; c < 6; c++) begin
      step();
      if (wp && first_c < 0) begin
        first_c = c;
        check(oe == '0, "R7 drive off with pulse", oe, 0);
      end
    end
    check(first_c == 3, "R5 wake latency", first_c, 3);
    watch(60, pc, dc);
    check(pc == 0 && dc == 0, "R7 quiet after wake", pc * 256 + dc, 0);
    key_on = 1'b0;
    leave_halt();
    halt = 1'b1;
    step();
    check(oe == 10'h001, "R8 restart at first line", oe, 1);
    watch(SLOT - 1, pc, dc);
    step();
    check(oe == 10'h002, "R8 full slot after restart", oe, 2);
    leave_halt();

    // R5: key on a later line pair, 2 and 6 enabled
    wen = 10'b0001000100; ka = 6; kb = 2; key_on = 1'b1;
    halt = 1'b1;
    first_c = -1;
    for (int c = 0; c < 10; c++) begin
      step();
      if (wp && first_c < 0) first_c = c;
    end
    check(first_c == 3, "R5 wake from second pair", first_c, 3);
    key_on = 1'b0;
    leave_halt();

    // R5: partner line disabled, no wake
    wen = 10'b0000000001; ka = 0; kb = 5; key_on = 1'b1;
    halt = 1'b1;
    watch(3 * (SLOT + GAP), pc, dc);
    check(pc == 0, "R5 disabled partner ignored", pc, 0);
    check(dc == 3 * SLOT, "R3 only enabled line driven", dc, 3 * SLOT);
    key_on = 1'b0;
    leave_halt();

    // R6: input-only line, no scan lines enabled
    wen = '0; solo_en = 1'b1; halt = 1'b1;
    watch(5, pc, dc);
    solo = 1'b0;
    first_c = -1;
    for (int c = 0; c < 8; c++) begin
      step();
      if (wp && first_c < 0) first_c = c;
      if (oe != '0) dc++;
    end
    check(first_c == 2, "R6 solo edge wake latency", first_c, 2);
    check(dc == 0, "R6 nothing driven with empty mask", dc, 0);
    leave_halt();
    solo_en = 1'b0; halt = 1'b1;
    step();
    solo = 1'b1;
    watch(20, pc, dc);
    check(pc == 0, "R6 solo edge ignored when disabled", pc, 0);
    leave_halt();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(1_900_000);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule